// File: doc/BRIEF.md
# Quasi-Bidirectional I/O Port with Latch-Directed Modify Path

This block is one general-purpose I/O port of a small microcontroller. An output latch drives the pad controls. A latched 0 turns on a pull-down. A latched 1 releases the pin, so it is held high only by a weak pull-up. Right after a 0-to-1 change, a strong pull-up is also on for one clock. An external device can then pull a released pin low, which lets the same pin act as an input. A build-time option gives an open-drain variant that has no pull-ups at all.

The CPU tells the block which class of instruction is using the port. Modify-class accesses (byte logic, increment, decrement, and the single-bit operations) read the latch, compute the new value, and write the whole byte back to the latch in one clock. Every other read returns the pin levels after a synchronizer. Reading the latch for modify-class accesses means a pin held low from outside cannot silently clear a latched 1 when another bit is changed.

Top module: `qb_port`

## Requirements
- R1: While reset is asserted, the latch is all ones, the synchronizer outputs are all ones, no pull-down is on, and no strong pull-up is on.
- R2: With `wr_en` high and no modify-class access, the latch takes `wr_data` at the next clock edge. `pad_pd` is always the bitwise inverse of the latch.
- R3: `rd_data` returns the latch contents whenever `acc_class` is a modify class (codes 1 to 11). For codes 0 and 12 to 15, it returns the synchronized pins. This depends only on `acc_class`, not on `acc_en`.
- R4: A change on `pad_in` appears on the pin read path after exactly two rising clock edges.
- R5: A modify access writes the result back to the latch at the next edge. The byte operations are: AND with operand (code 1), OR (2), XOR (3), increment (4), decrement (5), and decrement-and-test (6). Increment and decrement wrap modulo 2^WIDTH.
- R6: The bit operations act on bit `bit_sel` and leave every other latch bit unchanged. They are: jump-and-clear (7) clears the bit, complement (8), move carry (9) copies `carry_in`, clear (10), and set (11).
- R7: If a write and a modify access come in the same cycle, the modify result is stored. An access with a non-modify code changes nothing, so a write in that cycle is still stored.
- R8: In the default variant, `pad_wpu` equals the latch. A pin pulled low from outside reads 0 on the pin path while the latch path still reads 1. `pad_pd` and a pull-up are never on for the same bit.
- R9: In the default variant, `pad_spu` is high for exactly the one clock cycle after a latch bit goes from 0 to 1. It never stays high for two cycles in a row.
- R10: With `OPEN_DRAIN` set, `pad_wpu` and `pad_spu` stay 0 at all times, even right after a 0-to-1 latch change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Plain byte write strobe |
| wr_data | input | WIDTH | Plain byte write data |
| acc_en | input | 1 | Access strobe; with a modify code, performs the write-back |
| acc_class | input | 4 | Instruction class code of the current access |
| acc_operand | input | WIDTH | Operand for the byte logic operations |
| bit_sel | input | SEL_W | Bit index for the bit operations |
| carry_in | input | 1 | Carry value for the move-carry operation |
| rd_data | output | WIDTH | Read data: latch or synchronized pins |
| pad_in | input | WIDTH | Pin levels |
| pad_pd | output | WIDTH | Pull-down enable per pin |
| pad_wpu | output | WIDTH | Weak pull-up enable per pin |
| pad_spu | output | WIDTH | Strong pull-up enable per pin |

## Verification
The bench drives the pin of a latched 1 low from outside. It then checks that the pin path reads 0 while a modify class still reads 1. A design that read pins for modify accesses would return 0 and clear the bit on write-back. It checks that bit operations keep their neighbours, and that a same-cycle write loses to a modify access. It also times the synchronizer to the exact edge and checks the strong pull-up pulse width. A design that got these wrong would, in turn, corrupt other bits, store the plain write, read the pin one cycle early or late, or leave the strong pull-up on or never pulse it.

// File: rtl/qb_port_pkg.sv
package qb_port_pkg;

   typedef enum logic [3:0] {
      CLS_PLAIN = 4'd0,
      CLS_AND   = 4'd1,
      CLS_OR    = 4'd2,
      CLS_XOR   = 4'd3,
      CLS_INC   = 4'd4,
      CLS_DEC   = 4'd5,
      CLS_DJNZ  = 4'd6,
      CLS_JBC   = 4'd7,
      CLS_CPLB  = 4'd8,
      CLS_MOVC  = 4'd9,
      CLS_CLRB  = 4'd10,
      CLS_SETB  = 4'd11
   } acc_class_e;

   // Modify classes read the latch and write back to it.
   function automatic logic acc_is_modify(input logic [3:0] cls);
      return (cls >= 4'd1) && (cls <= 4'd11);
   endfunction

endpackage

// File: rtl/qb_port_sync.sv
module qb_port_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '1;
      end else begin
         chain_q[0] <= din;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/qb_port_modify.sv
module qb_port_modify
   import qb_port_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int SEL_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] cur,
   input  logic [3:0]       cls,
   input  logic [WIDTH-1:0] operand,
   input  logic [SEL_W-1:0] sel,
   input  logic             carry,
   output logic [WIDTH-1:0] nxt
);

   logic [WIDTH-1:0] mask;

   always_comb begin
      mask      = '0;
      mask[sel] = 1'b1;
   end

   always_comb begin
      nxt = cur;
      case (cls)
         CLS_AND:            nxt = cur & operand;
         CLS_OR:             nxt = cur | operand;
         CLS_XOR:            nxt = cur ^ operand;
         CLS_INC:            nxt = cur + WIDTH'(1);
         CLS_DEC, CLS_DJNZ:  nxt = cur - WIDTH'(1);
         CLS_JBC, CLS_CLRB:  nxt = cur & ~mask;
         CLS_CPLB:           nxt = cur ^ mask;
         CLS_MOVC:           nxt = carry ? (cur | mask) : (cur & ~mask);
         CLS_SETB:           nxt = cur | mask;
         default:            nxt = cur;
      endcase
   end

endmodule

// File: rtl/qb_port_drive.sv
module qb_port_drive #(
   parameter int WIDTH      = 8,
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch,
   output logic [WIDTH-1:0] pad_pd,
   output logic [WIDTH-1:0] pad_wpu,
   output logic [WIDTH-1:0] pad_spu
);

   assign pad_pd = ~latch;

   generate
      if (OPEN_DRAIN) begin : g_open_drain
         assign pad_wpu = '0;
         assign pad_spu = '0;
      end else begin : g_quasi
         logic [WIDTH-1:0] prev_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '1;
            else        prev_q <= latch;
         end

         assign pad_wpu = latch;
         assign pad_spu = latch & ~prev_q;

         // R9: the strong pull-up never lasts two cycles on the same bit
         assert_strong_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_spu & $past(pad_spu)) == '0);
      end
   endgenerate

   // R8: pull-down and any pull-up are never on together for a bit
   assert_drive_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pd & (pad_wpu | pad_spu)) == '0);

endmodule

// File: rtl/qb_port.sv
module qb_port
   import qb_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OPEN_DRAIN  = 1'b0,
   localparam int SEL_W      = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             acc_en,
   input  logic [3:0]       acc_class,
   input  logic [WIDTH-1:0] acc_operand,
   input  logic [SEL_W-1:0] bit_sel,
   input  logic             carry_in,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_pd,
   output logic [WIDTH-1:0] pad_wpu,
   output logic [WIDTH-1:0] pad_spu
);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $error("qb_port: WIDTH must be a power of two, at least 2");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("qb_port: SYNC_STAGES must lie in 2..4");
      end
   endgenerate

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] mod_next;
   logic [WIDTH-1:0] pin_sync;
   logic             mod_wr;

   assign mod_wr = acc_en && acc_is_modify(acc_class);

   qb_port_modify #(.WIDTH(WIDTH)) u_modify (
      .cur     (latch_q),
      .cls     (acc_class),
      .operand (acc_operand),
      .sel     (bit_sel),
      .carry   (carry_in),
      .nxt     (mod_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '1;
      else if (mod_wr) latch_q <= mod_next;
      else if (wr_en)  latch_q <= wr_data;
   end

   qb_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pin_sync)
   );

   assign rd_data = acc_is_modify(acc_class) ? latch_q : pin_sync;

   qb_port_drive #(.WIDTH(WIDTH), .OPEN_DRAIN(OPEN_DRAIN)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch   (latch_q),
      .pad_pd  (pad_pd),
      .pad_wpu (pad_wpu),
      .pad_spu (pad_spu)
   );

   // R2: plain write lands when no modify access competes
   assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mod_wr) |=> (latch_q == $past(wr_data)));

   // R7: a modify access stores the modify result, even beside a write
   assert_modify_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mod_wr |=> (latch_q == $past(mod_next)));

   // R7: with no write and no modify access the latch holds
   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !mod_wr) |=> $stable(latch_q));

   // R6: set-bit raises only the addressed bit
   assert_setb_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_class == CLS_SETB) |=>
      (latch_q == ($past(latch_q) | (WIDTH'(1) << $past(bit_sel)))));

endmodule

// File: tb/sim_qb_port.sv
`timescale 1ns/1ps
module sim_qb_port;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         acc_en = 1'b0;
   logic [3:0]   acc_class = 4'd0;
   logic [W-1:0] acc_operand = '0;
   logic [2:0]   bit_sel = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] ext_low = '0;
   logic [W-1:0] rd_data, pad_pd, pad_wpu, pad_spu, pad_in;
   logic [W-1:0] od_rd, od_pd, od_wpu, od_spu;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // Pin model: low if driven low by the port or by the outside device
   assign pad_in = ~pad_pd & ~ext_low;

   qb_port #(.WIDTH(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .acc_en(acc_en), .acc_class(acc_class), .acc_operand(acc_operand),
      .bit_sel(bit_sel), .carry_in(carry_in), .rd_data(rd_data),
      .pad_in(pad_in), .pad_pd(pad_pd), .pad_wpu(pad_wpu), .pad_spu(pad_spu)
   );

   qb_port #(.WIDTH(W), .OPEN_DRAIN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .acc_en(acc_en), .acc_class(acc_class), .acc_operand(acc_operand),
      .bit_sel(bit_sel), .carry_in(carry_in), .rd_data(od_rd),
      .pad_in(pad_in), .pad_pd(od_pd), .pad_wpu(od_wpu), .pad_spu(od_spu)
   );

   // {pre[31:24], class[23:20], operand[19:12], bit[11:9], carry[8], expected[7:0]}
   localparam logic [31:0] VEC [15] = '{
      {8'hA5, 4'd1,  8'h0F, 3'd0, 1'b0, 8'h05},
      {8'hA5, 4'd2,  8'h50, 3'd0, 1'b0, 8'hF5},
      {8'hA5, 4'd3,  8'hFF, 3'd0, 1'b0, 8'h5A},
      {8'hFF, 4'd4,  8'h00, 3'd0, 1'b0, 8'h00},
      {8'h00, 4'd5,  8'h00, 3'd0, 1'b0, 8'hFF},
      {8'h10, 4'd6,  8'h00, 3'd0, 1'b0, 8'h0F},
      {8'hFF, 4'd7,  8'h00, 3'd3, 1'b0, 8'hF7},
      {8'h0F, 4'd8,  8'h00, 3'd7, 1'b0, 8'h8F},
      {8'h0F, 4'd8,  8'h00, 3'd0, 1'b0, 8'h0E},
      {8'h00, 4'd9,  8'h00, 3'd5, 1'b1, 8'h20},
      {8'hFF, 4'd9,  8'h00, 3'd2, 1'b0, 8'hFB},
      {8'h00, 4'd11, 8'h00, 3'd6, 1'b0, 8'h40},
      {8'hFF, 4'd10, 8'h00, 3'd1, 1'b0, 8'hFD},
      {8'h3C, 4'd0,  8'hFF, 3'd0, 1'b0, 8'h3C},
      {8'h3C, 4'd13, 8'hFF, 3'd0, 1'b0, 8'h3C}
   };

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic set_latch(input logic [W-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v; acc_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      acc_class = 4'd1; #1;
      chk("R1", "latch during reset", rd_data, 8'hFF);
      chk("R1", "pull-down during reset", pad_pd, 8'h00);
      chk("R1", "strong pull-up during reset", pad_spu, 8'h00);
      acc_class = 4'd0; #1;
      chk("R1", "pin path during reset", rd_data, 8'hFF);
      rst_n = 1'b1;

      // R5 R6 R7 R3: vector table
      for (int i = 0; i < 15; i++) begin
         logic [31:0] v;
         string tag;
         v = VEC[i];
         if (v[23:20] >= 4'd1 && v[23:20] <= 4'd6)       tag = "R5";
         else if (v[23:20] >= 4'd7 && v[23:20] <= 4'd11) tag = "R6";
         else                                             tag = "R7";
         @(negedge clk);
         wr_en = 1'b1; wr_data = v[31:24]; acc_en = 1'b0; acc_class = 4'd0;
         @(negedge clk);
         wr_en = 1'b0; acc_en = 1'b1; acc_class = v[23:20];
         acc_operand = v[19:12]; bit_sel = v[11:9]; carry_in = v[8];
         #1;
         if (tag != "R7") chk("R3", "latch read during modify", rd_data, v[31:24]);
         @(negedge clk);
         acc_en = 1'b0; acc_class = 4'd1; #1;
         chk(tag, "latch after access", rd_data, v[7:0]);
      end

      // R2: plain write, pull-down follows inverse of latch
      set_latch(8'h96);
      acc_class = 4'd2; #1;
      chk("R2", "latch after write", rd_data, 8'h96);
      chk("R2", "pull-down pattern", pad_pd, 8'h69);

      // R7: modify beats a same-cycle write
      set_latch(8'h10);
      wr_en = 1'b1; wr_data = 8'h00; acc_en = 1'b1; acc_class = 4'd11; bit_sel = 3'd0;
      @(negedge clk);
      wr_en = 1'b0; acc_en = 1'b0; acc_class = 4'd1; #1;
      chk("R7", "modify over write", rd_data, 8'h11);
      // R7: non-modify class leaves the write in force
      wr_en = 1'b1; wr_data = 8'h55; acc_en = 1'b1; acc_class = 4'd0;
      @(negedge clk);
      wr_en = 1'b0; acc_en = 1'b0; acc_class = 4'd1; #1;
      chk("R7", "plain class with write", rd_data, 8'h55);

      // R4 R8: external pull-down, pin versus latch, sync latency
      set_latch(8'hFF);
      repeat (3) @(negedge clk);
      acc_class = 4'd0; #1;
      chk("R4", "pin path settled high", rd_data, 8'hFF);
      chk("R8", "weak pull-up equals latch", pad_wpu, 8'hFF);
      ext_low = 8'h01;
      @(negedge clk); #1;
      chk("R4", "pin path after one edge", rd_data, 8'hFF);
      @(negedge clk); #1;
      chk("R4", "pin path after two edges", rd_data, 8'hFE);
      chk("R8", "pin reads low under external pull", rd_data, 8'hFE);
      acc_class = 4'd8; #1;
      chk("R8", "latch still high under external pull", rd_data, 8'hFF);
      // R8: bit op on another bit must keep the externally pulled bit at 1
      acc_en = 1'b1; bit_sel = 3'd7;
      @(negedge clk);
      acc_en = 1'b0; acc_class = 4'd1; #1;
      chk("R8", "latch after bit op under external pull", rd_data, 8'h7F);
      ext_low = 8'h00;

      // R9 R10: strong pull-up pulse
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h00;
      @(negedge clk);
      wr_data = 8'hFF; #1;
      chk("R9", "no pulse on falling latch", pad_spu, 8'h00);
      @(negedge clk);
      wr_en = 1'b0; #1;
      chk("R9", "pulse after rising latch", pad_spu, 8'hFF);
      chk("R10", "open-drain strong pull-up", od_spu, 8'h00);
      chk("R10", "open-drain weak pull-up", od_wpu, 8'h00);
      chk("R10", "open-drain pull-down", od_pd, 8'h00);
      @(negedge clk); #1;
      chk("R9", "pulse ended", pad_spu, 8'h00);
      chk("R9", "weak pull-up held", pad_wpu, 8'hFF);

      finish_run();
   end

endmodule